// File: doc/BRIEF.md
# Zero-Page Single-Bit Execution Unit

This unit runs the four single-bit instruction families of an 8-bit core: force one bit of a zero-page byte to 0, force it to 1, and branch on that bit being 0 or being 1. A fetch stage hands over the opcode byte and the address of the byte that follows it with a one-cycle `start` strobe. The unit then fetches its own operand bytes, does the memory access over a byte-wide bus, and returns the updated program counter with a one-cycle `done` strobe.

The bit-modify forms use a locked read-modify-write of the zero-page byte. A first locked read captures the byte. A second locked read of the same address is a dummy, and its data is discarded. A locked write then stores the result. The bit-test forms fetch the zero-page address and then a signed displacement, read the byte, and resolve the branch in the same cycle. An opcode outside the four families raises a one-cycle error and touches nothing.

Top module: `bitop_unit`

## Requirements
- R1: An opcode is legal only when its bits 2:0 are 111. Bits 6:4 give the bit index n. Bit 3 selects test-and-branch (1) or modify (0). Bit 7 selects the polarity: 1 means set, or branch if the bit is 1; 0 means clear, or branch if the bit is 0. The legal opcodes are therefore 0x07/0x87/0x0F/0x8F plus 0x10*n.
- R2: The clear form writes back the byte read, with bit n forced to 0 and every other bit unchanged.
- R3: The set form writes back the byte read, with bit n forced to 1 and every other bit unchanged.
- R4: The modify form performs the following bus cycles in order:
  - an unlocked operand read at `pc_in`;
  - a locked read at 0x00zp;
  - a locked dummy read at 0x00zp, whose data has no effect on the written value;
  - a locked write at 0x00zp.
  `lock_n` is low for exactly the last three of these cycles.
- R5: A modify instruction takes four bus cycles, five counting the opcode fetch. `done` is high for exactly one cycle, the cycle after the write.
- R6: The branch-if-clear form takes the branch when bit n of the zero-page byte is 0.
- R7: The branch-if-set form takes the branch when bit n of the zero-page byte is 1.
- R8: The test form performs the following bus cycles, with `lock_n` high and no write:
  - a read of the zero-page address at `pc_in`;
  - a read of the displacement at `pc_in`+1;
  - a read at 0x00zp.
  In the next cycle `done` is high. `pc_out` is then `pc_in`+2 plus the sign-extended displacement if the branch is taken, and `pc_in`+2 if it is not.
- R9: Every program-counter step and branch target wraps modulo 2^16. For example, with `pc_in`=0xFFFF the displacement is read from 0x0000.
- R10: For an illegal opcode, `err` is high for exactly one cycle, the cycle after `start`. There is no bus strobe and no `done`.
- R11: After reset `rd_en`, `wr_en`, `done` and `err` are low, and `lock_n` is high.
- R12: After a modify instruction, `pc_out` equals `pc_in`+1 (mod 2^16) while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opcode and `pc_in` valid, one cycle, only while idle |
| opcode | input | 8 | Instruction byte |
| pc_in | input | ADDR_W | Address of the byte after the opcode |
| rdata | input | 8 | Read data, valid in the cycle `rd_en` is high |
| addr | output | ADDR_W | Bus address |
| rd_en | output | 1 | Read strobe |
| wr_en | output | 1 | Write strobe |
| wdata | output | 8 | Write data |
| lock_n | output | 1 | Low during the locked read-modify-write |
| pc_out | output | ADDR_W | Updated program counter, valid with `done` |
| done | output | 1 | Instruction finished, one cycle |
| err | output | 1 | Illegal opcode, one cycle |

## Verification
The bench builds the unit with its default 16-bit address width. This makes wraparound at 0xFFFF reachable with plain directed values: a displacement fetched from 0x0000, and a backward branch that crosses from low memory into 0xFFxx. On the dummy read, the bench memory model returns the complement of the stored byte, so a design that latched the second read would write a wrong value. Random legal and illegal opcodes, bit indices, byte contents and displacements cover both polarities of every family.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_OPND, S_DISP, S_TEST, S_LRD, S_LDUM, S_LWR, S_DONE
  } bitop_state_t;

  typedef struct packed {
    logic       legal;
    logic       is_test;
    logic       polarity;
    logic [2:0] idx;
  } bitop_dec_t;

  // Force one bit of a byte to a given value.
  function automatic logic [7:0] f_force_bit(input logic [7:0] b,
                                             input logic [2:0] idx,
                                             input logic       val);
    logic [7:0] m;
    m = 8'h01 << idx;
    return val ? (b | m) : (b & ~m);
  endfunction

  // True when bit idx of b equals the wanted polarity.
  function automatic logic f_bit_hit(input logic [7:0] b,
                                     input logic [2:0] idx,
                                     input logic       want);
    return b[idx] == want;
  endfunction

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
  import bitop_pkg::*;
(
  input  logic [7:0] opcode,
  output bitop_dec_t dec
);
  always_comb begin
    dec.legal    = (opcode[2:0] == 3'b111);
    dec.is_test  = opcode[3];
    dec.polarity = opcode[7];
    dec.idx      = opcode[6:4];
  end
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [7:0]        mod_byte,
  input  logic [7:0]        test_byte,
  input  logic [2:0]        idx,
  input  logic              polarity,
  input  logic [ADDR_W-1:0] pc_after,
  input  logic [7:0]        disp,
  output logic [7:0]        new_byte,
  output logic              taken,
  output logic [ADDR_W-1:0] target
);
  localparam int EXT_W = ADDR_W - 8;

  function automatic logic [ADDR_W-1:0] f_rel(input logic [ADDR_W-1:0] base,
                                              input logic [7:0] d);
    return base + {{EXT_W{d[7]}}, d};
  endfunction

  assign new_byte = f_force_bit(mod_byte, idx, polarity);
  assign taken    = f_bit_hit(test_byte, idx, polarity);
  assign target   = f_rel(pc_after, disp);
endmodule

// File: rtl/bitop_seq.sv
module bitop_seq
  import bitop_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  bitop_dec_t        dec_in,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [7:0]        rdata,
  input  logic [7:0]        new_byte,
  input  logic              taken,
  input  logic [ADDR_W-1:0] target,
  output logic [7:0]        data_q,
  output logic [7:0]        disp_q,
  output logic [2:0]        idx_q,
  output logic              pol_q,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] addr,
  output logic              rd_en,
  output logic              wr_en,
  output logic [7:0]        wdata,
  output logic              lock_n,
  output logic              done,
  output logic              err
);
  localparam int PAGE_W = ADDR_W - 8;

  bitop_state_t state;
  logic         test_q;
  logic [7:0]   zp_q;
  logic         err_q;

  // Named phase events for the assertions.
  logic fetch_phase, rmw_phase, zp_phase;
  assign fetch_phase = (state == S_OPND) || (state == S_DISP);
  assign rmw_phase   = (state == S_LRD) || (state == S_LDUM) || (state == S_LWR);
  assign zp_phase    = rmw_phase || (state == S_TEST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      pc_q   <= '0;
      zp_q   <= '0;
      disp_q <= '0;
      data_q <= '0;
      test_q <= 1'b0;
      pol_q  <= 1'b0;
      idx_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          if (dec_in.legal) begin
            test_q <= dec_in.is_test;
            pol_q  <= dec_in.polarity;
            idx_q  <= dec_in.idx;
            pc_q   <= pc_in;
            state  <= S_OPND;
          end else begin
            err_q <= 1'b1;
          end
        end
        S_OPND: begin
          zp_q  <= rdata;
          pc_q  <= pc_q + ADDR_W'(1);
          state <= test_q ? S_DISP : S_LRD;
        end
        S_DISP: begin
          disp_q <= rdata;
          pc_q   <= pc_q + ADDR_W'(1);
          state  <= S_TEST;
        end
        S_TEST: begin
          if (taken) pc_q <= target;
          state <= S_DONE;
        end
        S_LRD: begin
          data_q <= rdata;
          state  <= S_LDUM;
        end
        S_LDUM: state <= S_LWR;
        S_LWR:  state <= S_DONE;
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    addr   = zp_phase ? {{PAGE_W{1'b0}}, zp_q} : pc_q;
    rd_en  = fetch_phase || (state == S_TEST) || (state == S_LRD) || (state == S_LDUM);
    wr_en  = (state == S_LWR);
    wdata  = new_byte;
    lock_n = !rmw_phase;
    done   = (state == S_DONE);
    err    = err_q;
  end

  // R4: the write closes a locked run of two reads at the same address
  a_r4_write_after_locked_reads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (!lock_n && $past(!lock_n) && $past(!lock_n, 2) && $past(rd_en)
               && $past(addr) == addr));

  // R4: every locked cycle targets page zero
  a_r4_lock_in_page_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_n |-> (addr[ADDR_W-1:8] == '0));

  // R5: done is a single-cycle pulse with no bus activity
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!rd_en && !wr_en && lock_n) ##1 !done);

  // R10: an error cycle is quiet on the bus
  a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!rd_en && !wr_en && !done && lock_n));

  // R9: each operand fetch advances the program counter by one
  a_r9_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_phase |=> (pc_q == $past(pc_q) + ADDR_W'(1)));

  // R4: reads and writes never overlap
  a_r4_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [7:0]        rdata,
  output logic [ADDR_W-1:0] addr,
  output logic              rd_en,
  output logic              wr_en,
  output logic [7:0]        wdata,
  output logic              lock_n,
  output logic [ADDR_W-1:0] pc_out,
  output logic              done,
  output logic              err
);
  bitop_dec_t        dec;
  logic [7:0]        data_q, disp_q, new_byte;
  logic [2:0]        idx_q;
  logic              pol_q, taken;
  logic [ADDR_W-1:0] pc_q, target;

  bitop_decode u_dec (.opcode(opcode), .dec(dec));

  bitop_alu #(.ADDR_W(ADDR_W)) u_alu (
    .mod_byte(data_q), .test_byte(rdata), .idx(idx_q), .polarity(pol_q),
    .pc_after(pc_q), .disp(disp_q), .new_byte(new_byte), .taken(taken),
    .target(target)
  );

  bitop_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .dec_in(dec), .pc_in(pc_in),
    .rdata(rdata), .new_byte(new_byte), .taken(taken), .target(target),
    .data_q(data_q), .disp_q(disp_q), .idx_q(idx_q), .pol_q(pol_q), .pc_q(pc_q),
    .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .lock_n(lock_n),
    .done(done), .err(err)
  );

  assign pc_out = pc_q;
endmodule

// File: tb/test_bitop_unit.sv
module test_bitop_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [15:0] pc_in = 16'h0000;
  logic [7:0]  rdata;
  logic [15:0] addr, pc_out;
  logic        rd_en, wr_en, lock_n, done, err;
  logic [7:0]  wdata;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0] zp_mem [256];
  logic [7:0] opnd_b = 8'h00, disp_b = 8'h00;
  logic       br_mode = 1'b0;
  logic       clr_cnt = 1'b0;
  int         rdcnt = 0;

  always #5 clk = ~clk;

  bitop_unit i_bitop_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .pc_in(pc_in),
    .rdata(rdata), .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
    .lock_n(lock_n), .pc_out(pc_out), .done(done), .err(err)
  );

  // Memory model: reads are numbered per instruction. The dummy read of a
  // modify instruction returns the complement of the stored byte.
  always_comb begin
    if (rdcnt == 0)                 rdata = opnd_b;
    else if (rdcnt == 1 && br_mode) rdata = disp_b;
    else if (rdcnt == 2 && !br_mode) rdata = ~zp_mem[addr[7:0]];
    else                            rdata = zp_mem[addr[7:0]];
  end

  always @(posedge clk) begin
    if (clr_cnt)    rdcnt <= 0;
    else if (rd_en) rdcnt <= rdcnt + 1;
    if (wr_en) zp_mem[addr[7:0]] <= wdata;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [7:0] old,
                                          input logic [2:0] n, input logic v);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[b] = (b == int'(n)) ? v : old[b];
    return r;
  endfunction

  function automatic logic [15:0] exp_pc(input logic [15:0] pc, input logic [7:0] d,
                                         input logic tk);
    logic [15:0] base;
    int signed   off;
    base = pc + 16'd2;
    off  = d[7] ? int'(d) - 256 : int'(d);
    return tk ? 16'(int'(base) + off) : base;
  endfunction

  task automatic run_op(input logic [7:0] op, input logic [15:0] pc,
                        input logic [7:0] zpa, input logic [7:0] disp);
    logic       legal, tst, pol, bitv, tk;
    logic [2:0] n;
    logic [7:0] old, nb;
    logic [15:0] zaddr, pexp;
    legal = (op[2:0] == 3'b111);
    tst = op[3]; pol = op[7]; n = op[6:4];
    old = zp_mem[zpa];
    zaddr = {8'h00, zpa};
    @(negedge clk);
    opcode = op; pc_in = pc; opnd_b = zpa; disp_b = disp; br_mode = tst;
    clr_cnt = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; clr_cnt = 1'b0;
    if (!legal) begin
      check(err === 1'b1, "R10 err pulse", 32'(err), 1);
      check(!rd_en && !wr_en, "R10 no bus", {30'd0, rd_en, wr_en}, 0);
      check(zp_mem[zpa] === old, "R10 memory untouched", 32'(zp_mem[zpa]), 32'(old));
      @(negedge clk);
      check(!err && !done && !rd_en, "R10 single err, no done",
            {29'd0, err, done, rd_en}, 0);
      return;
    end
    check(rd_en && lock_n && addr == pc, "R8 R4 operand read at pc_in",
          {addr, 15'd0, rd_en}, {pc, 16'd1});
    if (tst) begin
      bitv = old[n];
      tk = pol ? bitv : !bitv;
      pexp = exp_pc(pc, disp, tk);
      @(negedge clk);
      check(rd_en && lock_n && addr == pc + 16'd1, "R9 R8 displacement read",
            32'(addr), 32'(pc + 16'd1));
      @(negedge clk);
      check(rd_en && lock_n && !wr_en && addr == zaddr, "R8 zero-page test read",
            32'(addr), 32'(zaddr));
      @(negedge clk);
      check(done === 1'b1, "R8 done after test read", 32'(done), 1);
      if (pol) check(pc_out == pexp, "R7 branch-if-set target", 32'(pc_out), 32'(pexp));
      else     check(pc_out == pexp, "R6 branch-if-clear target", 32'(pc_out), 32'(pexp));
    end else begin
      nb = exp_byte(old, n, pol);
      @(negedge clk);
      check(rd_en && !lock_n && addr == zaddr, "R4 locked read", 32'(addr), 32'(zaddr));
      @(negedge clk);
      check(rd_en && !lock_n && addr == zaddr, "R4 locked dummy read", 32'(addr), 32'(zaddr));
      @(negedge clk);
      check(wr_en && !lock_n && addr == zaddr, "R4 locked write", 32'(addr), 32'(zaddr));
      if (pol) check(wdata == nb, "R3 set-bit data", 32'(wdata), 32'(nb));
      else     check(wdata == nb, "R2 clear-bit data", 32'(wdata), 32'(nb));
      @(negedge clk);
      check(done && lock_n && !wr_en, "R5 done after write", 32'(done), 1);
      check(pc_out == pc + 16'd1, "R12 pc after modify", 32'(pc_out), 32'(pc + 16'd1));
    end
    @(negedge clk);
    check(done === 1'b0, "R5 done one cycle", 32'(done), 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0B17));
    for (int i = 0; i < 256; i++) zp_mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    check(!rd_en && !wr_en && !done && !err && lock_n, "R11 reset state",
          {27'd0, rd_en, wr_en, done, err, lock_n}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!rd_en && !wr_en && !done && !err && lock_n, "R11 idle after reset",
          {27'd0, rd_en, wr_en, done, err, lock_n}, 1);

    // Directed corners
    zp_mem[8'h40] = 8'hFF;
    run_op(8'h77, 16'h1234, 8'h40, 8'h00);           // R2 clear bit 7 of FF
    zp_mem[8'h41] = 8'h00;
    run_op(8'h87, 16'h2000, 8'h41, 8'h00);           // R3 set bit 0 of 00
    zp_mem[8'h42] = 8'hFE;
    run_op(8'h0F, 16'hFFFF, 8'h42, 8'h10);           // R6 R9 wrap, taken
    zp_mem[8'h43] = 8'h08;
    run_op(8'hBF, 16'h0001, 8'h43, 8'h80);           // R7 R9 backward wrap
    zp_mem[8'h44] = 8'h08;
    run_op(8'h3F, 16'h3000, 8'h44, 8'h7F);           // R6 not taken
    run_op(8'hF7, 16'hFFFF, 8'hFF, 8'h00);           // R12 R9 pc wraps to 0000
    run_op(8'h1A, 16'h4000, 8'h00, 8'h00);           // R10 R1 illegal
    run_op(8'h8E, 16'h4000, 8'h00, 8'h00);           // R10 R1 illegal

    // R1 constrained random mix of legal and illegal opcodes
    for (int k = 0; k < 300; k++) begin
      logic [7:0] op;
      op = 8'($urandom);
      if ($urandom_range(0, 4) != 0) op[2:0] = 3'b111;
      run_op(op, 16'($urandom), 8'($urandom), 8'($urandom));
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule